// File: doc/BRIEF.md
# Keyed Watchdog Timer with Separate Interrupt and Reset Thresholds

This block is a watchdog timer controlled through a small register bus with synchronous writes and combinational reads. An 8-bit counter advances on a slow tick. The tick comes from one of several tick-enable inputs, chosen by a rate code in the configuration word. Two compare values watch the same counter. The first marks an expiration in an interrupt status bit. The second emits a one-cycle system reset request.

Software keeps the watchdog quiet by writing a restart key, which returns the counter to zero. A second key locks the block until system reset. While locked, configuration writes are dropped and the timer runs whatever its enable bit says. The interrupt side has a status bit, an output enable and write-one set and clear registers. The tick generators, the interrupt controller and the reset controller are outside this block.

Top module: `keyed_watchdog`

## Requirements
- R1: The registers sit at these byte offsets: configuration 0x000, restart 0x004, lock 0x008, count 0x00C, interrupt enable 0x200, interrupt status 0x204, clear 0x208, set 0x20C. In the configuration word, bit 0 is the timer enable, bit 1 the interrupt enable, bit 2 the reset enable, bits 15:8 the reset compare value, bits 23:16 the interrupt compare value and bits 26:24 the rate code. Other bits read as 0.
- R2: Rate codes 1, 2, 3 and 4 select tick inputs 0, 1, 2 and 3 (128 Hz, 16 Hz, 1 Hz, 1/16 Hz). Codes 0 and 5 to 7 select no tick, so the counter holds.
- R3: While the timer is enabled, the counter advances by one on each clock with the selected tick high. It holds while disabled and saturates at 0xFF. It is readable at offset 0x00C in bits 7:0.
- R4: A write to the restart register whose low byte is 0xB2 returns the counter to 0 at the next edge, even when a tick arrives in the same cycle. Any other low byte leaves the counter unchanged.
- R5: A write to the lock register whose low byte is 0x3A locks the block. Any other value does not lock it. While locked, configuration writes are ignored, the timer runs, and bit 0 of the configuration reads 1. The lock state reads in bit 0 of offset 0x008.
- R6: The lock can only be released by system reset. No later write of any value clears it.
- R7: The interrupt status bit is set when the counter steps onto the interrupt compare value while configuration bit 1 is 1. With that bit at 0, no expiration is recorded. A compare value of 0 is never reached by stepping.
- R8: The interrupt output is high exactly when the status bit and bit 0 of the interrupt enable register are both 1.
- R9: Writing 1 in bit 0 of the clear register clears the status bit, and writing 1 in bit 0 of the set register sets it. A write with bit 0 at 0 changes nothing.
- R10: When an expiration and a clear land in the same cycle, the status bit ends up set.
- R11: The reset request is high for exactly one clock, on the edge where the counter steps onto the reset compare value, and only if configuration bit 2 is 1. A compare value of 0 never fires.
- R12: After reset, the counter, configuration, lock, interrupt enable and status are all 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_we_i | input | 1 | Write strobe, one write per clock |
| bus_addr_i | input | 12 | Byte offset for both reads and writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| tick_i | input | 4 | Tick enables, index 0 is the fastest rate |
| irq_o | output | 1 | Interrupt request |
| wdt_rst_o | output | 1 | One-cycle system reset request |

## Verification
The bench uses the default build: an 8-bit counter with four tick inputs. With a counter this small, every nonzero reset compare value and every nonzero interrupt compare value can be swept. For each value the bench checks the exact cycle of the reset pulse or the status rise, measured from the restart. All eight rate codes are tried against each of the four tick lines. The saturation point at 0xFF, the restart/tick collision and the clear/expiration collision are each reached within a few hundred clocks.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;
    localparam int RATE_W = 3;

    localparam logic [ADDR_W-1:0] OFS_CFG     = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_RESTART = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_LOCK    = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_COUNT   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_IE      = 12'h200;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 12'h204;
    localparam logic [ADDR_W-1:0] OFS_CLR     = 12'h208;
    localparam logic [ADDR_W-1:0] OFS_SET     = 12'h20C;

    localparam logic [7:0] KEY_RESTART = 8'hB2;
    localparam logic [7:0] KEY_LOCK    = 8'h3A;

    // Stored configuration fields
    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [CNT_W-1:0]  int_cmp;
        logic [CNT_W-1:0]  rst_cmp;
        logic              rst_en;
        logic              int_en;
        logic              run;
    } cfg_t;

    // One bus transfer as seen by the register file
    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
        cfg_t c;
        c.run     = w[0];
        c.int_en  = w[1];
        c.rst_en  = w[2];
        c.rst_cmp = w[15:8];
        c.int_cmp = w[23:16];
        c.rate    = w[26:24];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input cfg_t c);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[0]     = c.run;
        w[1]     = c.int_en;
        w[2]     = c.rst_en;
        w[15:8]  = c.rst_cmp;
        w[23:16] = c.int_cmp;
        w[26:24] = c.rate;
        return w;
    endfunction

endpackage

// File: rtl/kwd_regfile.sv
module kwd_regfile
    import kwd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  bus_req_t          req_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              status_i,
    output cfg_t              cfg_o,
    output logic              locked_o,
    output logic              ie_o,
    output logic              restart_o,
    output logic              sw_set_o,
    output logic              sw_clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    cfg_t cfg_q;
    logic locked_q;
    logic ie_q;

    logic wr_cfg, wr_restart, wr_lock, wr_ie, wr_clr, wr_set;

    always_comb begin
        wr_cfg     = req_i.we && (req_i.addr == OFS_CFG);
        wr_restart = req_i.we && (req_i.addr == OFS_RESTART);
        wr_lock    = req_i.we && (req_i.addr == OFS_LOCK);
        wr_ie      = req_i.we && (req_i.addr == OFS_IE);
        wr_clr     = req_i.we && (req_i.addr == OFS_CLR);
        wr_set     = req_i.we && (req_i.addr == OFS_SET);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q    <= '0;
            locked_q <= 1'b0;
            ie_q     <= 1'b0;
        end else begin
            if (wr_cfg && !locked_q)
                cfg_q <= word_to_cfg(req_i.wdata);
            if (wr_lock && (req_i.wdata[7:0] == KEY_LOCK))
                locked_q <= 1'b1;
            if (wr_ie)
                ie_q <= req_i.wdata[0];
        end
    end

    // A locked timer always runs
    always_comb begin
        cfg_o     = cfg_q;
        cfg_o.run = cfg_q.run | locked_q;
    end

    assign locked_o  = locked_q;
    assign ie_o      = ie_q;
    assign restart_o = wr_restart && (req_i.wdata[7:0] == KEY_RESTART);
    assign sw_set_o  = wr_set && req_i.wdata[0];
    assign sw_clr_o  = wr_clr && req_i.wdata[0];

    always_comb begin
        rdata_o = '0;
        case (req_i.addr)
            OFS_CFG:    rdata_o = cfg_to_word(cfg_o);
            OFS_LOCK:   rdata_o[0] = locked_q;
            OFS_COUNT:  rdata_o[CNT_W-1:0] = count_i;
            OFS_IE:     rdata_o[0] = ie_q;
            OFS_STATUS: rdata_o[0] = status_i;
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
    import kwd_pkg::*;
#(
    parameter int NUM_RATES = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 run_i,
    input  logic [RATE_W-1:0]    rate_i,
    input  logic [NUM_RATES-1:0] tick_i,
    input  logic                 restart_i,
    input  logic [CNT_W-1:0]     int_cmp_i,
    input  logic [CNT_W-1:0]     rst_cmp_i,
    output logic [CNT_W-1:0]     count_o,
    output logic                 int_hit_o,
    output logic                 rst_hit_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [NUM_RATES-1:0] tick_gated;
    logic                 tick_sel;
    logic [CNT_W-1:0]     count_q;
    logic [CNT_W-1:0]     count_nxt;
    logic                 advance;

    // Rate code k (1..NUM_RATES) picks tick line k-1; all other codes pick nothing
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        assign tick_gated[g] = tick_i[g] && (rate_i == RATE_W'(g + 1));
    end

    assign tick_sel  = |tick_gated;
    assign advance   = run_i && tick_sel && (count_q != CNT_MAX) && !restart_i;
    assign count_nxt = count_q + 1'b1;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            count_q <= '0;
        else if (restart_i)
            count_q <= '0;
        else if (advance)
            count_q <= count_nxt;
    end

    assign count_o   = count_q;
    assign int_hit_o = advance && (count_nxt == int_cmp_i);
    assign rst_hit_o = advance && (count_nxt == rst_cmp_i);

endmodule

// File: rtl/kwd_events.sv
module kwd_events
    import kwd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic int_hit_i,
    input  logic rst_hit_i,
    input  logic int_en_i,
    input  logic rst_en_i,
    input  logic ie_i,
    input  logic sw_set_i,
    input  logic sw_clr_i,
    output logic status_o,
    output logic irq_o,
    output logic rst_req_o
);

    logic status_q;
    logic rst_req_q;
    logic status_d;

    // Any set source overrides a clear in the same cycle
    always_comb begin
        status_d = status_q && !sw_clr_i;
        if ((int_hit_i && int_en_i) || sw_set_i)
            status_d = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            status_q  <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            status_q  <= status_d;
            rst_req_q <= rst_hit_i && rst_en_i;
        end
    end

    assign status_o  = status_q;
    assign irq_o     = status_q && ie_i;
    assign rst_req_o = rst_req_q;

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int NUM_RATES = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 bus_we_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    input  logic [NUM_RATES-1:0] tick_i,
    output logic                 irq_o,
    output logic                 wdt_rst_o
);

    bus_req_t         req;
    cfg_t             cfg_eff;
    logic             locked;
    logic             ie;
    logic             restart;
    logic             sw_set;
    logic             sw_clr;
    logic [CNT_W-1:0] count;
    logic             status;
    logic             int_hit;
    logic             rst_hit;

    assign req.we    = bus_we_i;
    assign req.addr  = bus_addr_i;
    assign req.wdata = bus_wdata_i;

    kwd_regfile u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .req_i     (req),
        .count_i   (count),
        .status_i  (status),
        .cfg_o     (cfg_eff),
        .locked_o  (locked),
        .ie_o      (ie),
        .restart_o (restart),
        .sw_set_o  (sw_set),
        .sw_clr_o  (sw_clr),
        .rdata_o   (bus_rdata_o)
    );

    kwd_counter #(.NUM_RATES(NUM_RATES)) u_cnt (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (cfg_eff.run),
        .rate_i    (cfg_eff.rate),
        .tick_i    (tick_i),
        .restart_i (restart),
        .int_cmp_i (cfg_eff.int_cmp),
        .rst_cmp_i (cfg_eff.rst_cmp),
        .count_o   (count),
        .int_hit_o (int_hit),
        .rst_hit_o (rst_hit)
    );

    kwd_events u_evt (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .int_hit_i (int_hit),
        .rst_hit_i (rst_hit),
        .int_en_i  (cfg_eff.int_en),
        .rst_en_i  (cfg_eff.rst_en),
        .ie_i      (ie),
        .sw_set_i  (sw_set),
        .sw_clr_i  (sw_clr),
        .status_o  (status),
        .irq_o     (irq_o),
        .rst_req_o (wdt_rst_o)
    );

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
    import kwd_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              irq_o,
    input logic              wdt_rst_o,
    input logic [CNT_W-1:0]  count_i,
    input logic              status_i,
    input logic              locked_i,
    input logic              ie_i,
    input logic              run_i,
    input logic              int_en_i,
    input logic              rst_en_i,
    input logic [CNT_W-1:0]  rst_cmp_i,
    input cfg_t              cfg_i
);

    logic set_wr;
    logic clr_wr;
    assign set_wr = bus_we_i && (bus_addr_i == OFS_SET) && bus_wdata_i[0];
    assign clr_wr = bus_we_i && (bus_addr_i == OFS_CLR) && bus_wdata_i[0];

    p_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(count_i) && (count_i != '0)) |-> (count_i == ($past(count_i) + 1'b1)));

    p_sat_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (count_i == {CNT_W{1'b1}}) |=> ((count_i == {CNT_W{1'b1}}) || (count_i == '0)));

    p_cfg_frozen_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        locked_i |=> $stable(cfg_i));

    p_run_locked_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        locked_i |-> run_i);

    p_lock_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        locked_i |=> locked_i);

    p_status_cause_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(status_i) |-> ($past(int_en_i) || $past(set_wr)));

    p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (status_i && ie_i));

    p_status_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_i && !clr_wr) |=> status_i);

    p_rst_pulse_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        wdt_rst_o |=> !wdt_rst_o);

    p_rst_at_cmp_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        wdt_rst_o |-> ((count_i == rst_cmp_i) && $past(rst_en_i)));

endmodule

bind keyed_watchdog kwd_checker u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .wdt_rst_o   (wdt_rst_o),
    .count_i     (count),
    .status_i    (status),
    .locked_i    (locked),
    .ie_i        (ie),
    .run_i       (cfg_eff.run),
    .int_en_i    (cfg_eff.int_en),
    .rst_en_i    (cfg_eff.rst_en),
    .rst_cmp_i   (cfg_eff.rst_cmp),
    .cfg_i       (cfg_eff)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  tick = '0;
    logic        irq;
    logic        wrst;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    keyed_watchdog u_keyed_watchdog (
        .clk_i       (clk),
        .rst_i       (rst),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .tick_i      (tick),
        .irq_o       (irq),
        .wdt_rst_o   (wrst)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [31:0] mk(input logic [2:0] rate, input logic [7:0] icmp,
                                       input logic [7:0] rcmp, input bit ren, input bit ien, input bit run);
        return {5'b0, rate, icmp, rcmp, 5'b0, ren, ien, run};
    endfunction

    task automatic do_reset();
        rst = 1'b1; we = 1'b0; tick = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog timeout actual=%h expected=%h", 0, 1);
        summary();
    end

    initial begin
        logic [31:0] v;
        int bad;
        bit seen;

        @(negedge clk);
        do_reset();

        // R12 reset state
        rd(12'h000, v); check(v == 0, "R12 cfg", v, 0);
        rd(12'h00C, v); check(v == 0, "R12 count", v, 0);
        rd(12'h008, v); check(v == 0, "R12 lock", v, 0);
        rd(12'h204, v); check(v == 0, "R12 status", v, 0);
        rd(12'h200, v); check(v == 0, "R12 ie", v, 0);
        check(irq == 0 && wrst == 0, "R12 outputs", {irq, wrst}, 0);

        // R1 field layout
        wr(12'h000, mk(3'd5, 8'hA5, 8'h5A, 1, 1, 0));
        rd(12'h000, v); check(v == 32'h05A55A06, "R1 cfg readback", v, 32'h05A55A06);
        wr(12'h000, 32'hFFFFFFFF);
        rd(12'h000, v); check(v == 32'h07FFFF07, "R1 reserved bits", v, 32'h07FFFF07);
        rd(12'h004, v); check(v == 0, "R1 restart reads zero", v, 0);

        // R2 rate code sweep against each tick line
        for (int code = 0; code < 8; code++) begin
            for (int j = 0; j < 4; j++) begin
                wr(12'h000, mk(code[2:0], 0, 0, 0, 0, 1));
                wr(12'h004, 32'hB2);
                tick = 4'(1 << j);
                repeat (10) @(negedge clk);
                tick = '0;
                rd(12'h00C, v);
                check(v == ((code == j + 1) ? 32'd10 : 32'd0), "R2 rate select", v,
                      (code == j + 1) ? 32'd10 : 32'd0);
            end
        end

        // R3 disabled timer holds
        wr(12'h000, mk(1, 0, 0, 0, 0, 0));
        wr(12'h004, 32'hB2);
        tick = 4'b0001; repeat (10) @(negedge clk); tick = '0;
        rd(12'h00C, v); check(v == 0, "R3 disabled hold", v, 0);

        // R3 saturation, zero compares never fire (R7, R11)
        wr(12'h208, 1);
        wr(12'h000, mk(1, 0, 0, 1, 1, 1));
        wr(12'h004, 32'hB2);
        seen = 0;
        tick = 4'b0001;
        repeat (300) begin @(negedge clk); if (wrst) seen = 1; end
        tick = '0;
        rd(12'h00C, v); check(v == 32'hFF, "R3 saturate", v, 32'hFF);
        check(!seen, "R11 zero compare silent", seen, 0);
        rd(12'h204, v); check(v == 0, "R7 zero compare silent", v, 0);

        // R4 restart key
        wr(12'h000, mk(1, 0, 0, 0, 0, 1));
        wr(12'h004, 32'hB2);
        tick = 4'b0001; repeat (7) @(negedge clk); tick = '0;
        wr(12'h004, 32'hB3);
        rd(12'h00C, v); check(v == 7, "R4 wrong key ignored", v, 7);
        wr(12'h004, 32'h000000B2 | 32'h12345600);
        rd(12'h00C, v); check(v == 0, "R4 key restart", v, 0);
        // restart beats a tick in the same cycle
        tick = 4'b0001; repeat (5) @(negedge clk);
        wr(12'h004, 32'hB2);
        tick = '0;
        rd(12'h00C, v); check(v == 0, "R4 restart over tick", v, 0);

        // R11 exhaustive reset compare sweep
        for (int r = 1; r < 256; r++) begin
            wr(12'h000, mk(1, 0, r[7:0], 1, 0, 1));
            wr(12'h004, 32'hB2);
            bad = 0;
            tick = 4'b0001;
            for (int n = 1; n <= r + 2; n++) begin
                @(negedge clk);
                if (wrst != (n == r)) bad++;
            end
            tick = '0;
            check(bad == 0, "R11 reset pulse timing", bad, 0);
        end
        wr(12'h000, mk(1, 0, 8'd20, 0, 0, 1));
        wr(12'h004, 32'hB2);
        seen = 0; tick = 4'b0001;
        repeat (25) begin @(negedge clk); if (wrst) seen = 1; end
        tick = '0;
        check(!seen, "R11 reset disabled", seen, 0);

        // R7 exhaustive interrupt compare sweep
        for (int r = 1; r < 256; r++) begin
            wr(12'h000, mk(1, r[7:0], 0, 0, 1, 1));
            wr(12'h208, 1);
            wr(12'h004, 32'hB2);
            bad = 0;
            tick = 4'b0001;
            for (int n = 1; n <= r + 1; n++) begin
                @(negedge clk);
                rd(12'h204, v);
                if (v[0] != (n >= r)) bad++;
            end
            tick = '0;
            check(bad == 0, "R7 status timing", bad, 0);
        end
        wr(12'h208, 1);
        wr(12'h000, mk(1, 8'd10, 0, 0, 0, 1));
        wr(12'h004, 32'hB2);
        tick = 4'b0001; repeat (15) @(negedge clk); tick = '0;
        rd(12'h204, v); check(v == 0, "R7 int disabled", v, 0);

        // R8 and R9 set, clear and output gating
        wr(12'h20C, 0);
        rd(12'h204, v); check(v == 0, "R9 set with zero", v, 0);
        wr(12'h20C, 1);
        rd(12'h204, v); check(v == 1, "R9 set", v, 1);
        check(irq == 0, "R8 irq gated off", irq, 0);
        wr(12'h200, 1);
        check(irq == 1, "R8 irq on", irq, 1);
        wr(12'h208, 0);
        rd(12'h204, v); check(v == 1, "R9 clear with zero", v, 1);
        wr(12'h208, 1);
        rd(12'h204, v); check(v == 0, "R9 clear", v, 0);
        check(irq == 0, "R8 irq follows status", irq, 0);

        // R10 expiration beats clear in the same cycle
        wr(12'h000, mk(1, 8'd5, 0, 0, 1, 1));
        wr(12'h004, 32'hB2);
        tick = 4'b0001;
        repeat (4) @(negedge clk);
        wr(12'h208, 1);
        tick = '0;
        rd(12'h00C, v); check(v == 5, "R10 count at hit", v, 5);
        rd(12'h204, v); check(v == 1, "R10 set wins", v, 1);

        // R5 lock
        wr(12'h000, mk(1, 0, 0, 0, 0, 0));
        wr(12'h008, 32'h3B);
        rd(12'h008, v); check(v == 0, "R5 wrong lock key", v, 0);
        wr(12'h008, 32'h3A);
        rd(12'h008, v); check(v == 1, "R5 locked", v, 1);
        rd(12'h000, v); check(v == 32'h01000001, "R5 enable forced", v, 32'h01000001);
        wr(12'h000, 32'hFFFFFFFF);
        rd(12'h000, v); check(v == 32'h01000001, "R5 cfg frozen", v, 32'h01000001);
        wr(12'h004, 32'hB2);
        tick = 4'b0001; repeat (6) @(negedge clk); tick = '0;
        rd(12'h00C, v); check(v == 6, "R5 runs when locked", v, 6);

        // R6 sticky lock
        wr(12'h008, 32'h00);
        wr(12'h008, 32'hFFFFFFFF);
        rd(12'h008, v); check(v == 1, "R6 lock sticky", v, 1);
        do_reset();
        rd(12'h008, v); check(v == 0, "R6 reset unlocks", v, 0);

        summary();
    end

endmodule